// File: doc/BRIEF.md
# All-Pairs Box Overlap Engine

This block finds every pair of overlapping axis-aligned boxes in a set of up to `NMAX` boxes. Each box is six single-precision values: the low and high bound on x, y and z. The user streams boxes in, one per cycle, while the engine is idle. Boxes take indices 0, 1, 2 and so on, in arrival order. A `go` pulse starts a run over the boxes loaded since the previous `go`. The engine then emits each overlapping pair as an index pair on a valid/ready stream. A one-cycle `done` pulse ends the run.

Throughput scales with a parallelism factor `M`. Each coordinate store is held `M` times, and every copy has two read ports, so 2M boxes can be read in each cycle. One port is held on a reference box. The other 2M-1 ports sweep the later boxes in strides of 2M-1, so each cycle tests one reference against up to 2M-1 candidates. Hits collect in a small buffer that drains one pair per cycle. The sweep pauses while that buffer lacks room for the results still in the pipeline.

Top module: `aabb_pairs`

## Requirements
- R1: Accepted boxes are stored at consecutive indices from 0. A box presented while `go` is high, while `busy` is high, or when `NMAX` boxes are already held is ignored. Accepting `go` resets the next load index to 0.
- R2: Two boxes overlap when, on every axis, the low bound of each is less than or equal to the high bound of the other. Touching faces (equal values) count as overlap.
- R3: Bounds are IEEE 754 single-precision values and are ordered as real numbers, negative values included. NaN is outside the contract, and -0 is treated as just below +0.
- R4: Each overlapping pair among the loaded boxes is emitted exactly once, with `pair_i` < `pair_j`. No non-overlapping pair is emitted.
- R5: Pairs leave in ascending order of `pair_i`, and then in ascending order of `pair_j`.
- R6: No pair names an index at or above the loaded count, including when that count is not a multiple of 2M-1.
- R7: While `pair_valid` is high and `pair_ready` is low, `pair_valid`, `pair_i` and `pair_j` hold. No pair is lost however long the output stalls.
- R8: `done` is high for exactly one cycle, after the last pair has been accepted. In that cycle `busy` and `pair_valid` are low. `busy` is high from the cycle after an accepted `go` until `done`.
- R9: A run with zero or one loaded box emits no pair and still ends with `done`.
- R10: A `go` pulse while `busy` is high has no effect on the run in progress.
- R11: After reset, `busy`, `pair_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Box present on the load inputs |
| ld_xlo | input | 32 | Low x bound, single precision |
| ld_xhi | input | 32 | High x bound |
| ld_ylo | input | 32 | Low y bound |
| ld_yhi | input | 32 | High y bound |
| ld_zlo | input | 32 | Low z bound |
| ld_zhi | input | 32 | High z bound |
| go | input | 1 | Start a run over the loaded boxes |
| busy | output | 1 | Run in progress |
| pair_valid | output | 1 | Pair present on the output |
| pair_ready | input | 1 | Consumer accepts the pair |
| pair_i | output | $clog2(NMAX) | Lower index of the overlapping pair |
| pair_j | output | $clog2(NMAX) | Higher index of the overlapping pair |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two things can happen in the same cycle: a burst of up to 2M-1 hits entering the hit buffer, and the output stream refusing a pair. When they coincide, the sweep must pause without dropping or repeating hits. The bench provokes this with 32 identical boxes, so every candidate hits in every cycle, while `pair_ready` is mostly held low and a stray `go` arrives mid-run. Every accepted pair is compared, as it is accepted, against a brute-force list kept in lexicographic order. Any lost, repeated or reordered pair therefore shows up at the first handshake where it differs.

// File: rtl/aabb_pkg.sv
package aabb_pkg;
  // coordinate slots inside a box word: 0 xlo, 1 xhi, 2 ylo, 3 yhi, 4 zlo, 5 zhi
  localparam int NCOORD = 6;
  typedef logic [NCOORD-1:0][31:0] box_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH} seq_st_t;

  // monotone map from float bit pattern to an unsigned sort key
  function automatic logic [31:0] f32_key(input logic [31:0] f);
    return f[31] ? ~f : (f ^ 32'h8000_0000);
  endfunction
endpackage

// File: rtl/aabb_bank.sv
module aabb_bank #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [IW-1:0] a_addr,
  input  logic [31:0]   a_wd,
  input  logic [IW-1:0] b_addr,
  output logic [31:0]   a_q,
  output logic [31:0]   b_q
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd;
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/overlap_unit.sv
module overlap_unit
  import aabb_pkg::*;
(
  input  box_t rf,
  input  box_t cd,
  output logic hit
);
  always_comb begin
    hit = 1'b1;
    for (int a = 0; a < 3; a++) begin
      if (!((f32_key(rf[2*a]) <= f32_key(cd[2*a+1])) &&
            (f32_key(rf[2*a+1]) >= f32_key(cd[2*a]))))
        hit = 1'b0;
    end
  end
endmodule

// File: rtl/pair_seq.sv
module pair_seq
  import aabb_pkg::*;
#(
  parameter int NMAX = 32,
  parameter int C    = 3,
  parameter int AW   = 7,
  parameter int IW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] n_in,
  input  logic          space_ok,
  input  logic          drained,
  output logic          issue,
  output logic [IW-1:0] ref_addr,
  output logic [IW-1:0] base_addr,
  output logic [C-1:0]  cand_ok,
  output logic          busy,
  output logic          done
);
  seq_st_t       st;
  logic [AW-1:0] ref_q, base_q, n_q, last;
  logic          pass_end;

  assign last      = n_q - AW'(1);
  assign pass_end  = (base_q + AW'(C - 1)) >= last;
  assign issue     = (st == S_RUN) && space_ok;
  assign ref_addr  = ref_q[IW-1:0];
  assign base_addr = base_q[IW-1:0];
  assign busy      = (st != S_IDLE);

  always_comb begin
    for (int k = 0; k < C; k++)
      cand_ok[k] = issue && ((base_q + AW'(k)) <= last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      ref_q  <= '0;
      base_q <= '0;
      n_q    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          n_q    <= n_in;
          ref_q  <= '0;
          base_q <= AW'(1);
          st     <= (n_in < AW'(2)) ? S_FLUSH : S_RUN;
        end
        S_RUN: if (issue) begin
          if (pass_end) begin
            if (ref_q == last - AW'(1)) st <= S_FLUSH;
            ref_q  <= ref_q + AW'(1);
            base_q <= ref_q + AW'(2);
          end else begin
            base_q <= base_q + AW'(C);
          end
        end
        default: if (drained) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  // R5: the reference holds while candidates sweep forward by the stride
  a_r5_ref_hold: assert property (@(posedge clk) disable iff (rst)
    (issue && !pass_end) |=> (ref_q == $past(ref_q)) && (base_q == $past(base_q) + AW'(C)));
  // R8: end-of-run marker is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: a start request during a run leaves the run length untouched
  a_r10_go_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && go) |=> $stable(n_q));
endmodule

// File: rtl/aabb_pairs.sv
module aabb_pairs
  import aabb_pkg::*;
#(
  parameter int NMAX     = 32,
  parameter int M        = 2,
  parameter int HB_DEPTH = 16,
  localparam int IW = $clog2(NMAX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_valid,
  input  logic [31:0]   ld_xlo,
  input  logic [31:0]   ld_xhi,
  input  logic [31:0]   ld_ylo,
  input  logic [31:0]   ld_yhi,
  input  logic [31:0]   ld_zlo,
  input  logic [31:0]   ld_zhi,
  input  logic          go,
  output logic          busy,
  output logic          pair_valid,
  input  logic          pair_ready,
  output logic [IW-1:0] pair_i,
  output logic [IW-1:0] pair_j,
  output logic          done
);
  localparam int C     = 2 * M - 1;
  localparam int AW    = IW + 2;
  localparam int HW    = $clog2(HB_DEPTH);
  localparam int CW    = $clog2(HB_DEPTH + 1);
  localparam int SLACK = HB_DEPTH - 3 * C;  // HB_DEPTH must be at least 3C

  // ---------------- load side ----------------
  logic [AW-1:0] ld_cnt;
  logic          ld_acc;
  box_t          ld_box;

  assign ld_box = {ld_zhi, ld_zlo, ld_yhi, ld_ylo, ld_xhi, ld_xlo};
  assign ld_acc = ld_valid && !busy && !go && (ld_cnt < AW'(NMAX));

  always_ff @(posedge clk) begin
    if (rst)                ld_cnt <= '0;
    else if (go && !busy)   ld_cnt <= '0;
    else if (ld_acc)        ld_cnt <= ld_cnt + AW'(1);
  end

  // ---------------- sequencer ----------------
  logic          issue, space_ok, drained;
  logic [IW-1:0] ref_addr, base_addr;
  logic [C-1:0]  cand_ok;
  logic [IW-1:0] cand_addr [C];

  pair_seq #(.NMAX(NMAX), .C(C), .AW(AW), .IW(IW)) u_seq (
    .clk, .rst, .go, .n_in(ld_cnt), .space_ok, .drained,
    .issue, .ref_addr, .base_addr, .cand_ok, .busy, .done
  );

  for (genvar k = 0; k < C; k++) begin : g_cand
    assign cand_addr[k] = base_addr + IW'(k);
  end

  // ---------------- replicated coordinate stores ----------------
  box_t qa_box [M];
  box_t qb_box [M];
  box_t cbox   [C];

  for (genvar g = 0; g < M; g++) begin : g_grp
    logic [IW-1:0] pa, pb;
    if (g == 0) begin : g_ref
      assign pa = ld_acc ? ld_cnt[IW-1:0] : ref_addr;
    end else begin : g_cnd
      assign pa = ld_acc ? ld_cnt[IW-1:0] : cand_addr[2*g-1];
    end
    assign pb = cand_addr[2*g];
    for (genvar c = 0; c < NCOORD; c++) begin : g_crd
      aabb_bank #(.DEPTH(NMAX)) u_bank (
        .clk, .a_we(ld_acc), .a_addr(pa), .a_wd(ld_box[c]),
        .b_addr(pb), .a_q(qa_box[g][c]), .b_q(qb_box[g][c])
      );
    end
  end

  // candidate k sits on read port k+1: group (k+1)/2, port A if even
  for (genvar k = 0; k < C; k++) begin : g_map
    if ((k + 1) % 2 == 0) begin : g_a
      assign cbox[k] = qa_box[(k+1)/2];
    end else begin : g_b
      assign cbox[k] = qb_box[(k+1)/2];
    end
  end

  // ---------------- compare pipeline ----------------
  logic          v1;
  logic [C-1:0]  ok1, ov, hit2;
  logic [IW-1:0] ref1, base1, ref2, base2;

  for (genvar k = 0; k < C; k++) begin : g_cmp
    overlap_unit u_ov (.rf(qa_box[0]), .cd(cbox[k]), .hit(ov[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      hit2 <= '0;
    end else begin
      v1   <= issue;
      hit2 <= v1 ? (ok1 & ov) : '0;
    end
    ok1   <= cand_ok;
    ref1  <= ref_addr;
    base1 <= base_addr;
    ref2  <= ref1;
    base2 <= base1;
  end

  // ---------------- hit buffer ----------------
  logic [IW-1:0] pi_buf [HB_DEPTH];
  logic [IW-1:0] pj_buf [HB_DEPTH];
  logic [HW-1:0] wp, rp;
  logic [HW-1:0] widx [C];
  logic [CW-1:0] cnt;
  int            npush;
  logic          pop;

  always_comb begin
    npush = 0;
    for (int k = 0; k < C; k++) begin
      widx[k] = wp + HW'(npush);
      if (hit2[k]) npush = npush + 1;
    end
  end

  assign pop      = (cnt != '0) && (!pair_valid || pair_ready);
  assign space_ok = (int'(cnt) <= SLACK);
  assign drained  = !v1 && (hit2 == '0) && (cnt == '0) && !pair_valid;

  always_ff @(posedge clk) begin
    for (int k = 0; k < C; k++) begin
      if (hit2[k]) begin
        pi_buf[widx[k]] <= ref2;
        pj_buf[widx[k]] <= base2 + IW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp         <= '0;
      rp         <= '0;
      cnt        <= '0;
      pair_valid <= 1'b0;
      pair_i     <= '0;
      pair_j     <= '0;
    end else begin
      wp  <= wp + HW'(npush);
      rp  <= rp + HW'(pop);
      cnt <= cnt + CW'(npush) - CW'(pop);
      if (pop) begin
        pair_valid <= 1'b1;
        pair_i     <= pi_buf[rp];
        pair_j     <= pj_buf[rp];
      end else if (pair_ready) begin
        pair_valid <= 1'b0;
      end
    end
  end

  // R7: the buffer never receives more hits than it can hold
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) + npush) <= HB_DEPTH);
  // R7: a refused pair stays put
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && !pair_ready) |=> pair_valid && $stable(pair_i) && $stable(pair_j));
  // R4: lower index first
  a_r4_order: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> (pair_i < pair_j));
  // R8: quiet outputs on the end pulse
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!pair_valid && !busy));
endmodule

// File: tb/sim_aabb_pairs.sv
`timescale 1ns/1ps
module sim_aabb_pairs;
  localparam int NMAX = 32;
  localparam int M    = 2;
  localparam int IW   = $clog2(NMAX);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic [31:0]   ld_xlo = '0, ld_xhi = '0, ld_ylo = '0, ld_yhi = '0, ld_zlo = '0, ld_zhi = '0;
  logic          go = 1'b0;
  logic          busy, pair_valid, done;
  logic          pair_ready = 1'b1;
  logic [IW-1:0] pair_i, pair_j;

  int checks = 0;
  int errors = 0;
  int bx [NMAX][6];
  int model_n = 0;
  int exp_i [$];
  int exp_j [$];

  always #10 clk = ~clk;

  aabb_pairs #(.NMAX(NMAX), .M(M), .HB_DEPTH(16)) u0 (
    .clk, .rst, .ld_valid, .ld_xlo, .ld_xhi, .ld_ylo, .ld_yhi, .ld_zlo, .ld_zhi,
    .go, .busy, .pair_valid, .pair_ready, .pair_i, .pair_j, .done
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] f32(input int v);
    int a, p;
    logic [7:0] e;
    logic [31:0] sh;
    if (v == 0) return 32'h0;
    a = (v < 0) ? -v : v;
    p = 0;
    for (int b = 0; b < 24; b++) if (a >= (1 << b)) p = b;
    e = 8'(127 + p);
    sh = 32'(a) << (23 - p);
    return {(v < 0), e, sh[22:0]};
  endfunction

  task automatic put_box(input int xl, input int xh, input int yl, input int yh,
                         input int zl, input int zh);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_xlo = f32(xl); ld_xhi = f32(xh);
    ld_ylo = f32(yl); ld_yhi = f32(yh);
    ld_zlo = f32(zl); ld_zhi = f32(zh);
    if (model_n < NMAX) begin
      bx[model_n] = '{xl, xh, yl, yh, zl, zh};
      model_n++;
    end
  endtask

  task automatic end_load();
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  function automatic bit ovl(input int a, input int b);
    for (int x = 0; x < 3; x++)
      if (!(bx[a][2*x] <= bx[b][2*x+1] && bx[a][2*x+1] >= bx[b][2*x])) return 1'b0;
    return 1'b1;
  endfunction

  // rmode: 0 always ready, 1 random, 2 mostly refused
  task automatic run_case(input int rmode, input bit stray_go, input string tag);
    int seen = 0;
    int total;
    bit fin = 0;
    exp_i.delete();
    exp_j.delete();
    for (int i = 0; i < model_n; i++)
      for (int j = i + 1; j < model_n; j++)
        if (ovl(i, j)) begin exp_i.push_back(i); exp_j.push_back(j); end
    total = exp_i.size();
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy == 1'b1, {"R8 busy after go ", tag}, int'(busy), 1);
    for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
      if (cyc != 0) @(negedge clk);
      go = (stray_go && cyc == 5);
      if (done) begin
        fin = 1;
      end else begin
        case (rmode)
          0: pair_ready = 1'b1;
          1: pair_ready = ($urandom_range(0, 1) == 1);
          default: pair_ready = ($urandom_range(0, 3) == 0);
        endcase
        if (pair_valid && pair_ready) begin
          if (exp_i.size() == 0) begin
            check(1'b0, {"R4 extra pair ", tag}, int'(pair_i) * 100 + int'(pair_j), -1);
          end else begin
            // R5 R6 R2 R3: next pair in ascending order from the brute-force list
            check(pair_i == IW'(exp_i[0]) && pair_j == IW'(exp_j[0]),
                  {"R5 pair sequence ", tag},
                  int'(pair_i) * 100 + int'(pair_j), exp_i[0] * 100 + exp_j[0]);
            void'(exp_i.pop_front());
            void'(exp_j.pop_front());
          end
          seen++;
        end
      end
    end
    go = 1'b0;
    pair_ready = 1'b1;
    check(fin, {"R8 done reached ", tag}, int'(fin), 1);
    check(seen == total, {"R4 pair count ", tag}, seen, total);
    check(!pair_valid && !busy, {"R8 quiet at done ", tag}, int'(pair_valid) + 2 * int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, {"R8 single done pulse ", tag}, int'(done), 0);
    model_n = 0;
  endtask

  initial begin
    #(20 * 180000);
    check(1'b0, "R8 watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check(!busy && !pair_valid && !done, "R11 reset outputs",
          int'(busy) + 2 * int'(pair_valid) + 4 * int'(done), 0);

    // R9: empty set and single box
    run_case(0, 1'b0, "empty");
    put_box(0, 5, 0, 5, 0, 5);
    end_load();
    run_case(0, 1'b0, "single");

    // R2 R4 R5: eight identical boxes, every pair hits
    for (int k = 0; k < 8; k++) put_box(1, 4, 1, 4, 1, 4);
    end_load();
    run_case(0, 1'b0, "all8");

    // R2: chain of boxes touching face to face along x only
    for (int k = 0; k < 9; k++) put_box(2 * k, 2 * k + 2, 0, 1, 0, 1);
    end_load();
    run_case(1, 1'b0, "touch");

    // R3 R7: random boxes with negative bounds, random backpressure
    for (int k = 0; k < 20; k++) begin
      int xl = $urandom_range(0, 70) - 40;
      int yl = $urandom_range(0, 70) - 40;
      int zl = $urandom_range(0, 70) - 40;
      put_box(xl, xl + $urandom_range(1, 30), yl, yl + $urandom_range(1, 30),
              zl, zl + $urandom_range(1, 30));
    end
    end_load();
    run_case(1, 1'b0, "rand20");

    // R6: count not a multiple of the candidate stride
    for (int k = 0; k < 13; k++) begin
      int xl = $urandom_range(0, 40) - 20;
      put_box(xl, xl + 12, -8, -1, -30, -2);
    end
    end_load();
    run_case(0, 1'b0, "rand13");

    // R7 R10: full capacity, all hit, output mostly refused, stray go mid-run
    for (int k = 0; k < NMAX; k++) put_box(-3, 3, -3, 3, -3, 3);
    end_load();
    run_case(2, 1'b1, "full32");

    // R1: disjoint boxes fill the store, a 33rd enclosing box is dropped
    for (int k = 0; k < NMAX; k++) put_box(3 * k, 3 * k + 1, 0, 1, 0, 1);
    put_box(-500, 500, -500, 500, -500, 500);
    end_load();
    run_case(0, 1'b0, "overfill");

    // R1: load index restarts at 0 after a run
    put_box(0, 1, 0, 1, 0, 1);
    put_box(5, 6, 5, 6, 5, 6);
    put_box(0, 6, 0, 6, 0, 6);
    end_load();
    run_case(0, 1'b0, "reload");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule